// File: doc/BRIEF.md
# Dual-Channel Dithered PWM Driver

This block drives two LED channels from a single shared phase-correct counter. Each channel takes a wide brightness level. The upper bits of the level set an integer PWM duty. The lower bits are a fraction, which a first-order delta-sigma accumulator turns into an occasional extra count of duty. Over a full dither cycle the average on-time follows the whole level, so the resolution is finer than one PWM step.

Each channel also drives an enable line for its output driver. The line is high when the channel has a nonzero level or when the caller forces it on. A load strobe applies both levels at once, and the compare values take effect in the same cycle. After a load, later duty changes from the dither happen only at the period boundary. A separate off strobe stops everything: the dither, both duties, both enables and the counter phase.

Top module: `dual_dither_pwm`

## Requirements
- R1: A channel level L splits into a base duty B = L >> FRAC_W and a fraction F = the low FRAC_W bits. Once the block settles after a load, any window of 2^FRAC_W consecutive PWM periods holds exactly 2*L high cycles on that channel's PWM output.
- R2: An input level above (2^DUTY_W - 1) << FRAC_W is treated as that maximum value.
- R3: The shared counter counts up from 0 to 2^DUTY_W - 1 and then back down to 0, holding one cycle at each end, so one period is 2^(DUTY_W+1) cycles. A PWM output is registered and is high in the cycle after the counter value lies below the channel's compare value.
- R4: On a load, each enable output becomes 1 if that channel's level is nonzero or its force flag is set, and 0 otherwise. Between loads and offs the enables do not change.
- R5: A set force flag with a zero level raises the enable and keeps the PWM output low.
- R6: A load writes B into the compare register in the same clock edge that it is taken, and it turns the dither on.
- R7: If both compare values are zero and both enables are low at the time of a load, the counter restarts at 0 counting up.
- R8: If either channel is on at the time of a load, the counter phase continues without a break.
- R9: An off strobe stops the dither, clears both levels, compare values and accumulators, resets the counter to 0 and drops both enables. Two cycles later both PWM outputs are low.
- R10: When off and load are asserted together, off takes effect and the load is ignored.
- R11: After reset, both PWM outputs and both enables are low.
- R12: At each period boundary the compare register takes the duty computed at the previous boundary, and then the next duty is computed. The accumulator adds F, the next duty is B plus the accumulator's carry bit, and the carry is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Apply level_a, level_b and the force flags |
| off | input | 1 | Turn both channels fully off; overrides load |
| level_a | input | DUTY_W+FRAC_W | Channel A brightness level |
| level_b | input | DUTY_W+FRAC_W | Channel B brightness level |
| force_a | input | 1 | Keep channel A driver enabled at any level |
| force_b | input | 1 | Keep channel B driver enabled at any level |
| pwm_a | output | 1 | Channel A PWM output |
| pwm_b | output | 1 | Channel B PWM output |
| en_a | output | 1 | Channel A driver enable |
| en_b | output | 1 | Channel B driver enable |

## Verification
The bench builds the block with DUTY_W = 4 and FRAC_W = 3. This gives a 32-cycle PWM period, a dither cycle of 8 periods, and 121 legal levels. With these sizes the bench can sweep every legal level on channel A, with the mirrored level on channel B. For each level it compares the exact high-cycle count over one dither cycle with 2*L. The small period also lets the bench predict the counter phase cycle by cycle, so it can tell a restarted phase from a kept one at the PWM pins.

// File: rtl/dual_dither_pwm_pkg.sv
package dual_dither_pwm_pkg;
  typedef enum logic {
    CNT_DOWN = 1'b0,
    CNT_UP   = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/dither_phase_counter.sv
module dither_phase_counter
  import dual_dither_pwm_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt,
  output logic         boundary
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  cnt_dir_e dir_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      dir_q <= CNT_UP;
    end else if (dir_q == CNT_UP) begin
      if (cnt == TOP) dir_q <= CNT_DOWN;
      else            cnt   <= cnt + 1'b1;
    end else begin
      if (cnt == '0) dir_q <= CNT_UP;
      else           cnt   <= cnt - 1'b1;
    end
  end

  // last cycle of a period: bottom of the down ramp
  assign boundary = (dir_q == CNT_DOWN) && (cnt == '0);
endmodule

// File: rtl/dither_pwm_channel.sv
module dither_pwm_channel #(
  parameter int DUTY_W = 8,
  parameter int FRAC_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     off,
  input  logic                     tick,
  input  logic [DUTY_W-1:0]        cnt,
  input  logic [DUTY_W+FRAC_W-1:0] level_in,
  input  logic                     force_on,
  output logic                     pwm,
  output logic                     en,
  output logic                     active
);
  localparam int LVL_W = DUTY_W + FRAC_W;
  localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(((1 << DUTY_W) - 1) << FRAC_W);

  logic [LVL_W-1:0]  lvl_q;
  logic [LVL_W-1:0]  lvl_c;
  logic [FRAC_W-1:0] acc_q;
  logic [FRAC_W:0]   acc_sum;
  logic [DUTY_W:0]   cmp_q;
  logic [DUTY_W:0]   nxt_q;
  logic [DUTY_W:0]   base_q;
  logic [DUTY_W:0]   base_c;

  assign lvl_c   = (level_in > LVL_MAX) ? LVL_MAX : level_in;
  assign base_c  = {1'b0, lvl_c[LVL_W-1:FRAC_W]};
  assign base_q  = {1'b0, lvl_q[LVL_W-1:FRAC_W]};
  assign acc_sum = {1'b0, acc_q} + {1'b0, lvl_q[FRAC_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst || off) begin
      lvl_q <= '0;
      acc_q <= '0;
      cmp_q <= '0;
      nxt_q <= '0;
      en    <= 1'b0;
    end else if (load) begin
      lvl_q <= lvl_c;
      cmp_q <= base_c;
      nxt_q <= base_c;
      en    <= (lvl_c != '0) || force_on;
    end else if (tick) begin
      // apply the staged duty first, then stage the following one
      cmp_q <= nxt_q;
      nxt_q <= base_q + (DUTY_W+1)'(acc_sum[FRAC_W]);
      acc_q <= acc_sum[FRAC_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pwm <= 1'b0;
    else     pwm <= ({1'b0, cnt} < cmp_q);
  end

  assign active = en || (cmp_q != '0);
endmodule

// File: rtl/dual_dither_pwm.sv
module dual_dither_pwm #(
  parameter int DUTY_W = 8,
  parameter int FRAC_W = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic                     off,
  input  logic [DUTY_W+FRAC_W-1:0] level_a,
  input  logic [DUTY_W+FRAC_W-1:0] level_b,
  input  logic                     force_a,
  input  logic                     force_b,
  output logic                     pwm_a,
  output logic                     pwm_b,
  output logic                     en_a,
  output logic                     en_b
);
  localparam int LVL_W = DUTY_W + FRAC_W;
  localparam int NCH   = 2;

  logic [DUTY_W-1:0] phase_cnt;
  logic              boundary;
  logic              dsm_on_q;
  logic              cnt_clr;
  logic [LVL_W-1:0]  lvl_in [NCH];
  logic [NCH-1:0]    frc_in;
  logic [NCH-1:0]    pwm_o;
  logic [NCH-1:0]    en_o;
  logic [NCH-1:0]    act_o;

  assign lvl_in[0] = level_a;
  assign lvl_in[1] = level_b;
  assign frc_in    = {force_b, force_a};

  // restart phase only when everything was dark before the load
  assign cnt_clr = off || (load && (act_o == '0));

  always_ff @(posedge clk) begin
    if (rst || off) dsm_on_q <= 1'b0;
    else if (load)  dsm_on_q <= 1'b1;
  end

  dither_phase_counter #(.W(DUTY_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (cnt_clr),
    .cnt      (phase_cnt),
    .boundary (boundary)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dither_pwm_channel #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_ch (
      .clk      (clk),
      .rst      (rst),
      .load     (load),
      .off      (off),
      .tick     (boundary && dsm_on_q),
      .cnt      (phase_cnt),
      .level_in (lvl_in[g]),
      .force_on (frc_in[g]),
      .pwm      (pwm_o[g]),
      .en       (en_o[g]),
      .active   (act_o[g])
    );
  end

  assign pwm_a = pwm_o[0];
  assign pwm_b = pwm_o[1];
  assign en_a  = en_o[0];
  assign en_b  = en_o[1];
endmodule

// File: rtl/dual_dither_pwm_checker.sv
module dual_dither_pwm_checker #(
  parameter int DUTY_W = 8,
  parameter int FRAC_W = 7
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     load,
  input logic                     off,
  input logic                     force_a,
  input logic                     force_b,
  input logic [DUTY_W+FRAC_W-1:0] level_a,
  input logic [DUTY_W+FRAC_W-1:0] level_b,
  input logic                     en_a,
  input logic                     en_b,
  input logic                     pwm_a,
  input logic                     pwm_b,
  input logic [DUTY_W-1:0]        phase_cnt
);
  AST_OFF_DROPS_EN: assert property (@(posedge clk) disable iff (rst)
    off |=> (!en_a && !en_b)); // R9
  AST_OFF_ZERO_PHASE: assert property (@(posedge clk) disable iff (rst)
    off |=> (phase_cnt == '0)); // R9
  AST_OFF_QUIETS_PWM: assert property (@(posedge clk) disable iff (rst)
    off |-> ##2 (!pwm_a && !pwm_b)); // R9
  AST_FORCE_EN_A: assert property (@(posedge clk) disable iff (rst)
    (load && !off && force_a) |=> en_a); // R5
  AST_FORCE_EN_B: assert property (@(posedge clk) disable iff (rst)
    (load && !off && force_b) |=> en_b); // R5
  AST_ZERO_LEVEL_EN: assert property (@(posedge clk) disable iff (rst)
    (load && !off && !force_a && (level_a == '0)) |=> !en_a); // R4
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !off) |=> ($stable(en_a) && $stable(en_b))); // R4
endmodule

bind dual_dither_pwm dual_dither_pwm_checker #(.DUTY_W(DUTY_W), .FRAC_W(FRAC_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .load      (load),
  .off       (off),
  .force_a   (force_a),
  .force_b   (force_b),
  .level_a   (level_a),
  .level_b   (level_b),
  .en_a      (en_a),
  .en_b      (en_b),
  .pwm_a     (pwm_a),
  .pwm_b     (pwm_b),
  .phase_cnt (phase_cnt)
);

// File: tb/dual_dither_pwm_test.sv
`timescale 1ns/1ps
module dual_dither_pwm_test;
  localparam int DW     = 4;
  localparam int FW     = 3;
  localparam int LW     = DW + FW;
  localparam int PER    = 2 << DW;            // 32 cycles per period
  localparam int WIN    = PER << FW;          // one full dither cycle
  localparam int LMAX   = ((1 << DW) - 1) << FW;
  localparam int SETTLE = 3 * PER + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0, off = 1'b0;
  logic [LW-1:0] level_a = '0, level_b = '0;
  logic force_a = 1'b0, force_b = 1'b0;
  logic pwm_a, pwm_b, en_a, en_b;

  int nchk = 0;
  int nfail = 0;
  bit timed_out = 1'b0;

  always #4 clk = ~clk;

  dual_dither_pwm #(.DUTY_W(DW), .FRAC_W(FW)) uut (
    .clk(clk), .rst(rst), .load(load), .off(off),
    .level_a(level_a), .level_b(level_b),
    .force_a(force_a), .force_b(force_b),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .en_a(en_a), .en_b(en_b)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // returns at the falling edge after the load edge
  task automatic do_load(input int a, input int b, input bit fa, input bit fb,
                         input bit with_off);
    @(negedge clk);
    level_a = LW'(a); level_b = LW'(b);
    force_a = fa; force_b = fb;
    load = 1'b1; off = with_off;
    @(negedge clk);
    load = 1'b0; off = 1'b0;
  endtask

  task automatic do_off();
    @(negedge clk);
    off = 1'b1;
    @(negedge clk);
    off = 1'b0;
  endtask

  task automatic measure(output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < WIN; i++) begin
      @(negedge clk);
      ha += int'(pwm_a);
      hb += int'(pwm_b);
    end
  endtask

  task automatic run_all();
    int ha, hb;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11: reset state
    check("R11 pwm_a", pwm_a, 0);
    check("R11 pwm_b", pwm_b, 0);
    check("R11 en_a", en_a, 0);
    check("R11 en_b", en_b, 0);

    // R1 R12: full sweep of legal levels, mirrored on B
    for (int lv = 0; lv <= LMAX; lv++) begin
      do_load(lv, LMAX - lv, 1'b0, 1'b0, 1'b0);
      check("R4 en_a", en_a, int'(lv != 0));
      check("R4 en_b", en_b, int'(lv != LMAX));
      repeat (SETTLE) @(negedge clk);
      measure(ha, hb);
      check("R1 high count a", ha, 2 * lv);
      check("R12 high count b", hb, 2 * (LMAX - lv));
    end

    // R2: out-of-range levels clamp to the maximum
    do_load(127, LMAX + 1, 1'b0, 1'b0, 1'b0);
    repeat (SETTLE) @(negedge clk);
    measure(ha, hb);
    check("R2 clamp a", ha, 2 * LMAX);
    check("R2 clamp b", hb, 2 * LMAX);

    // R9: off while running
    do_off();
    check("R9 en_a", en_a, 0);
    check("R9 en_b", en_b, 0);
    @(negedge clk);
    measure(ha, hb);
    check("R9 dark a", ha, 0);
    check("R9 dark b", hb, 0);

    // R5: force with zero level
    do_load(0, 0, 1'b1, 1'b0, 1'b0);
    check("R5 en_a", en_a, 1);
    check("R5 en_b", en_b, 0);
    measure(ha, hb);
    check("R5 pwm_a low", ha, 0);

    // R10: off beats a simultaneous load
    do_load(80, 80, 1'b1, 1'b1, 1'b1);
    check("R10 en_a", en_a, 0);
    check("R10 en_b", en_b, 0);
    measure(ha, hb);
    check("R10 dark a", ha, 0);

    // R6 R7 R3: load from dark, duty 5, frac 0; edge L restarts phase
    do_load(40, 0, 1'b0, 1'b0, 1'b0);
    check("R6 pwm_a after L", pwm_a, 0);
    @(negedge clk);
    check("R7 pwm_a after L+1", pwm_a, 1);
    repeat (4) @(negedge clk);
    check("R6 pwm_a after L+5", pwm_a, 1);
    @(negedge clk);
    check("R3 pwm_a after L+6", pwm_a, 0);
    repeat (21) @(negedge clk);
    check("R3 pwm_a after L+27", pwm_a, 0);
    @(negedge clk);
    check("R3 pwm_a after L+28", pwm_a, 1);

    // R8: reload while on at counter index 29 (value 2), duty 1
    do_load(8, 0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 pwm_a after L1+1", pwm_a, 0);
    repeat (2) @(negedge clk);
    check("R8 pwm_a after L1+3", pwm_a, 1);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule